// File: doc/BRIEF.md
# Banked System Interrupt Router

This block gathers up to ninety-six level-sensitive peripheral interrupt lines, arranged as three banks of thirty-two. For every bank it keeps a status register, a mask register and a wakeup-enable register. Status bits follow the input levels: a bit is 1 while its line is high and 0 once the line drops. No status bit is held after its line falls.

Every line has its own 4-bit route field. The field picks which of nine core event outputs the line drives. The outputs stand for event levels 7 to 15. A line that is pending and unmasked raises the output whose level is 7 plus its field value. Field values above 8 do not select any output.

A small synchronous register port gives read and write access to the mask, wakeup and route registers, and read-only access to status. A separate output requests wakeup whenever a pending line has its wakeup enable set.

Top module: `irq_router`

## Requirements
- R1: While reset is high at a clock edge, every mask register becomes 0x00000000, every status register becomes 0x00000000 and every wakeup register becomes 0xFFFFFFFF.
- R2: Reset loads route registers 0, 1 and 2 with 0x10000000, 0x33322221 and 0x66655444. Route registers 3 to 11 reset to 0x00000000.
- R3: Status bit j of bank b equals input line 32*b+j as it was sampled at the previous clock edge. A read at address 0x00+b returns bank b status. A write to a status address changes nothing.
- R4: Route register n is at address 0x10+n, for n from 0 to 11. The field of line i is bits [4*(i mod 8)+3 : 4*(i mod 8)] of route register i/8. Output bit k of `event_o` (level 7+k) is high in the same cycle as the registers whenever at least one line has its status bit and its mask bit both set and a field equal to k. Otherwise the bit is low.
- R5: A line whose route field is 9 to 15 drives no bit of `event_o`.
- R6: `wake_req_o` is high exactly when some line has both its status bit and its wakeup bit set. The wakeup register of bank b is at address 0x08+b.
- R7: The mask register of bank b is at address 0x04+b. A write with `reg_wr` high to a mask, wakeup or route address takes effect at the next clock edge. A read at that address then returns the written value, combinationally from `reg_addr`.
- R8: Any address not listed above is unmapped. A write to it leaves every register unchanged, and a read from it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 96 | Level interrupt lines; bit 32*b+j is line j of bank b |
| reg_addr | input | 6 | Register word address |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| event_o | output | 9 | Event requests; bit k is level 7+k |
| wake_req_o | output | 1 | Wakeup request |

## Verification
An input line reaches status one clock edge after it is sampled. `event_o` and `wake_req_o` are combinational from the registers, so they are valid in that same cycle. A register write likewise takes effect one edge after the strobe, while a read is due in the cycle its address is applied. The bench changes inputs on the falling clock edge and checks outputs at the following falling edge, which lies after exactly one rising edge. Reads are checked one nanosecond after the address is set, still before the next rising edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int BANKS      = 3;
    localparam int BANK_W     = 32;
    localparam int FIELD_W    = 4;
    localparam int LEVELS     = 9;
    localparam int BASE_LEVEL = 7;
    localparam int ADDR_W     = 6;
    localparam int IDX_W      = 5;

    localparam int LINES         = BANKS * BANK_W;
    localparam int FIELDS_PER_RG = BANK_W / FIELD_W;
    localparam int ROUTE_REGS    = LINES / FIELDS_PER_RG;

    localparam int STAT_BASE  = 0;
    localparam int MASK_BASE  = 4;
    localparam int WAKE_BASE  = 8;
    localparam int ROUTE_BASE = 16;

    typedef logic [BANK_W-1:0]                bank_word_t;
    typedef logic [BANKS-1:0][BANK_W-1:0]     bank_set_t;
    typedef logic [ROUTE_REGS-1:0][BANK_W-1:0] route_set_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_WAKE,
        SEL_ROUTE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(logic [ADDR_W-1:0] a);
        reg_dec_t d;
        int       v;
        v     = int'(a);
        d.sel = SEL_NONE;
        d.idx = '0;
        if (v >= STAT_BASE && v < STAT_BASE + BANKS) begin
            d.sel = SEL_STAT;
            d.idx = IDX_W'(v - STAT_BASE);
        end else if (v >= MASK_BASE && v < MASK_BASE + BANKS) begin
            d.sel = SEL_MASK;
            d.idx = IDX_W'(v - MASK_BASE);
        end else if (v >= WAKE_BASE && v < WAKE_BASE + BANKS) begin
            d.sel = SEL_WAKE;
            d.idx = IDX_W'(v - WAKE_BASE);
        end else if (v >= ROUTE_BASE && v < ROUTE_BASE + ROUTE_REGS) begin
            d.sel = SEL_ROUTE;
            d.idx = IDX_W'(v - ROUTE_BASE);
        end
        return d;
    endfunction

    function automatic bank_word_t route_reset_value(int n);
        case (n)
            0:       return 32'h1000_0000;
            1:       return 32'h3332_2221;
            2:       return 32'h6665_5444;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bank_word_t lines_i,
    input  logic       wr_mask,
    input  logic       wr_wake,
    input  bank_word_t wdata,
    output bank_word_t status_q,
    output bank_word_t mask_q,
    output bank_word_t wake_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
            wake_q   <= '1;
        end else begin
            status_q <= lines_i;
            if (wr_mask) mask_q <= wdata;
            if (wr_wake) wake_q <= wdata;
        end
    end

endmodule

// File: rtl/irq_route_file.sv
module irq_route_file
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  bank_word_t       wdata,
    output route_set_t       route_q
);

    for (genvar n = 0; n < ROUTE_REGS; n++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                route_q[n] <= route_reset_value(n);
            else if (wr_en && int'(wr_idx) == n)
                route_q[n] <= wdata;
        end
    end

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
    import irq_router_pkg::*;
(
    input  logic [LINES-1:0]  active_i,
    input  route_set_t        route_i,
    output logic [LEVELS-1:0] event_o
);

    always_comb begin
        logic [FIELD_W-1:0] fld;
        event_o = '0;
        for (int i = 0; i < LINES; i++) begin
            fld = route_i[i / FIELDS_PER_RG][(i % FIELDS_PER_RG) * FIELD_W +: FIELD_W];
            for (int k = 0; k < LEVELS; k++) begin
                if (active_i[i] && int'(fld) == k)
                    event_o[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  irq_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [LEVELS-1:0] event_o,
    output logic              wake_req_o
);

    reg_dec_t         dec;
    bank_set_t        status_all;
    bank_set_t        mask_all;
    bank_set_t        wake_all;
    route_set_t       route_q;
    logic [LINES-1:0] active;
    logic [LINES-1:0] waking;

    assign dec = decode_addr(reg_addr);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit = reg_wr && int'(dec.idx) == b;

        irq_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .lines_i  (irq_i[b*BANK_W +: BANK_W]),
            .wr_mask  (hit && dec.sel == SEL_MASK),
            .wr_wake  (hit && dec.sel == SEL_WAKE),
            .wdata    (reg_wdata),
            .status_q (status_all[b]),
            .mask_q   (mask_all[b]),
            .wake_q   (wake_all[b])
        );

        assign active[b*BANK_W +: BANK_W] = status_all[b] & mask_all[b];
        assign waking[b*BANK_W +: BANK_W] = status_all[b] & wake_all[b];
    end

    irq_route_file u_route (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr && dec.sel == SEL_ROUTE),
        .wr_idx  (dec.idx),
        .wdata   (reg_wdata),
        .route_q (route_q)
    );

    irq_level_router u_lvl (
        .active_i (active),
        .route_i  (route_q),
        .event_o  (event_o)
    );

    assign wake_req_o = |waking;

    always_comb begin
        reg_rdata = '0;
        case (dec.sel)
            SEL_STAT:
                for (int b = 0; b < BANKS; b++)
                    if (int'(dec.idx) == b) reg_rdata = status_all[b];
            SEL_MASK:
                for (int b = 0; b < BANKS; b++)
                    if (int'(dec.idx) == b) reg_rdata = mask_all[b];
            SEL_WAKE:
                for (int b = 0; b < BANKS; b++)
                    if (int'(dec.idx) == b) reg_rdata = wake_all[b];
            SEL_ROUTE:
                for (int n = 0; n < ROUTE_REGS; n++)
                    if (int'(dec.idx) == n) reg_rdata = route_q[n];
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [LINES-1:0]  irq_i,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input bank_set_t         status_all,
    input bank_set_t         mask_all,
    input bank_set_t         wake_all,
    input route_set_t        route_q,
    input logic [LEVELS-1:0] event_o,
    input logic              wake_req_o
);

    logic [LINES-1:0] st_f;
    logic [LINES-1:0] mk_f;
    logic [LINES-1:0] wk_f;
    reg_dec_t         cdec;

    assign st_f = status_all;
    assign mk_f = mask_all;
    assign wk_f = wake_all;
    assign cdec = decode_addr(reg_addr);

    assert_reset_banks_R1: assert property (@(posedge clk)
        rst |=> (mk_f == '0 && st_f == '0 && wk_f == '1));

    assert_reset_routes_R2: assert property (@(posedge clk)
        rst |=> (route_q[0] == 32'h1000_0000 && route_q[1] == 32'h3332_2221
                 && route_q[2] == 32'h6665_5444));

    assert_status_follows_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_f == $past(irq_i)));

    assert_event_needs_active_R4: assert property (@(posedge clk) disable iff (rst)
        (|event_o) |-> (|(st_f & mk_f)));

    assert_wake_needs_pending_R6: assert property (@(posedge clk) disable iff (rst)
        wake_req_o |-> (|(st_f & wk_f)));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && cdec.sel == SEL_NONE) |=>
            ($stable(mk_f) && $stable(wk_f) && $stable(route_q)));

endmodule

bind irq_router irq_router_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_i      (irq_i),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .status_all (status_all),
    .mask_all   (mask_all),
    .wake_all   (wake_all),
    .route_q    (route_q),
    .event_o    (event_o),
    .wake_req_o (wake_req_o)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
    import irq_router_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LINES-1:0]  irq_i = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [LEVELS-1:0] event_o;
    logic              wake_req_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] m_mask  [BANKS];
    logic [31:0] m_wake  [BANKS];
    logic [31:0] m_route [ROUTE_REGS];

    always #2 clk = ~clk;

    irq_router u_irq_router (
        .clk(clk), .rst(rst), .irq_i(irq_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .event_o(event_o), .wake_req_o(wake_req_o)
    );

    function automatic logic [LEVELS-1:0] exp_events();
        logic [LEVELS-1:0] e = '0;
        for (int i = 0; i < LINES; i++) begin
            int f;
            f = int'(m_route[i / 8][(i % 8) * 4 +: 4]);
            if (irq_i[i] && m_mask[i / 32][i % 32] && f < LEVELS) e[f] = 1'b1;
        end
        return e;
    endfunction

    function automatic logic exp_wake();
        logic w = 1'b0;
        for (int i = 0; i < LINES; i++)
            if (irq_i[i] && m_wake[i / 32][i % 32]) w = 1'b1;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        if (a >= MASK_BASE && a < MASK_BASE + BANKS) m_mask[a - MASK_BASE] = d;
        else if (a >= WAKE_BASE && a < WAKE_BASE + BANKS) m_wake[a - WAKE_BASE] = d;
        else if (a >= ROUTE_BASE && a < ROUTE_BASE + ROUTE_REGS) m_route[a - ROUTE_BASE] = d;
    endtask

    task automatic rd_check(input string tag, input int a, input logic [31:0] exp);
        reg_addr = ADDR_W'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic set_lines(input logic [LINES-1:0] v);
        @(negedge clk);
        irq_i = v;
        @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " R4 event_o"}, 32'(event_o), 32'(exp_events()));
        check({tag, " R6 wake_req_o"}, 32'(wake_req_o), 32'(exp_wake()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd2718));
        for (int b = 0; b < BANKS; b++) begin
            m_mask[b] = '0;
            m_wake[b] = '1;
        end
        for (int n = 0; n < ROUTE_REGS; n++) m_route[n] = '0;
        m_route[0] = 32'h1000_0000;
        m_route[1] = 32'h3332_2221;
        m_route[2] = 32'h6665_5444;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state of bank registers
        for (int b = 0; b < BANKS; b++) begin
            rd_check("R1 mask reset", MASK_BASE + b, 32'h0);
            rd_check("R1 wake reset", WAKE_BASE + b, 32'hFFFF_FFFF);
            rd_check("R1 status reset", STAT_BASE + b, 32'h0);
        end
        // R2 reset state of route registers
        for (int n = 0; n < ROUTE_REGS; n++)
            rd_check("R2 route reset", ROUTE_BASE + n, m_route[n]);
        check_outputs("R1 idle");

        // R4 single line routed to level 7+5
        wr(ROUTE_BASE + 0, (m_route[0] & ~32'h0000_F000) | 32'h0000_5000);
        wr(MASK_BASE + 0, 32'h0000_0008);
        set_lines(96'h8);
        check("R4 line3 to bit5", 32'(event_o), 32'h20);
        check_outputs("R4 directed");

        // R5 field above 8 routes nowhere
        wr(ROUTE_BASE + 0, (m_route[0] & ~32'h0000_F000) | 32'h0000_C000);
        check("R5 field 12 silent", 32'(event_o), 32'h0);
        wr(ROUTE_BASE + 0, (m_route[0] & ~32'h0000_F000) | 32'h0000_9000);
        check("R5 field 9 silent", 32'(event_o), 32'h0);

        // R6 wake request follows wake enables
        check("R6 wake on", 32'(wake_req_o), 32'h1);
        wr(WAKE_BASE + 0, 32'h0);
        check("R6 wake off", 32'(wake_req_o), 32'h0);

        // R3 status follows input, write to status ignored
        set_lines({32'hA5A5_0001, 32'h0000_FF00, 32'h1234_5678});
        rd_check("R3 status bank1", STAT_BASE + 1, 32'h0000_FF00);
        wr(STAT_BASE + 1, 32'hFFFF_FFFF);
        rd_check("R3 status write ignored", STAT_BASE + 1, 32'h0000_FF00);
        set_lines('0);
        rd_check("R3 status clears", STAT_BASE + 2, 32'h0);

        // R8 unmapped addresses
        wr(11, 32'hDEAD_BEEF);
        wr(63, 32'hDEAD_BEEF);
        wr(3, 32'hDEAD_BEEF);
        rd_check("R8 read 11", 11, 32'h0);
        rd_check("R8 read 63", 63, 32'h0);
        for (int b = 0; b < BANKS; b++) begin
            rd_check("R8 mask untouched", MASK_BASE + b, m_mask[b]);
            rd_check("R8 wake untouched", WAKE_BASE + b, m_wake[b]);
        end
        for (int n = 0; n < ROUTE_REGS; n++)
            rd_check("R8 route untouched", ROUTE_BASE + n, m_route[n]);

        // R7 / R4 / R6 random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: wr(MASK_BASE + int'($urandom_range(0, BANKS - 1)), $urandom);
                1: wr(WAKE_BASE + int'($urandom_range(0, BANKS - 1)), $urandom & $urandom);
                2: wr(ROUTE_BASE + int'($urandom_range(0, ROUTE_REGS - 1)), $urandom);
                default: ;
            endcase
            set_lines({$urandom & $urandom, $urandom & $urandom, $urandom & $urandom});
            check_outputs("R4 R6 random");
            if (op == 0) begin
                for (int b = 0; b < BANKS; b++)
                    rd_check("R7 mask readback", MASK_BASE + b, m_mask[b]);
            end else if (op == 1) begin
                for (int b = 0; b < BANKS; b++)
                    rd_check("R7 wake readback", WAKE_BASE + b, m_wake[b]);
            end else if (op == 2) begin
                for (int n = 0; n < ROUTE_REGS; n++)
                    rd_check("R7 route readback", ROUTE_BASE + n, m_route[n]);
            end else begin
                rd_check("R3 status random", STAT_BASE, irq_i[31:0]);
            end
        end

        // R1 reset re-applied mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check("R1 mask after reset", MASK_BASE + 2, 32'h0);
        rd_check("R1 wake after reset", WAKE_BASE + 1, 32'hFFFF_FFFF);
        rd_check("R2 route after reset", ROUTE_BASE + 1, 32'h3332_2221);

        summary();
    end

endmodule